// File: doc/BRIEF.md
# Compare-and-skip PC sequencer

This block steers the program counter of a simple in-order core around one instruction: compare two registers and skip the next instruction when they are equal. Each cycle it looks at the 16-bit word fetched at the current PC. It extracts the two 5-bit register selects so the register file can return the operand values in the same cycle. It then compares those values.

The PC steps by one word on every clock. When the compare finds the operands equal, the block raises `squash` for each following word that belongs to the skipped instruction: one word if the fetch side reports a one-word successor, two words if it reports a two-word successor. The compare therefore costs one, two or three cycles, and the next executed word sits at PC+1, PC+2 or PC+3 relative to the compare. The block writes no register and no status flag. Any other instruction simply lets the PC advance.

Top module: `skip_pc_sequencer`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc` to 0 and `squash` to 0. The reset is synchronous and active-low.
- R2: Outside reset, `pc` increases by exactly 1 on every clock edge and wraps from 16'hFFFF to 16'h0000.
- R3: `rd_sel` equals {instr_word[8], instr_word[7:4]} and `rr_sel` equals {instr_word[9], instr_word[3:0]}. A word is a compare-and-skip only when instr_word[15:10] equals 6'b000100.
- R4: When the word is not a compare-and-skip, or when `rd_data` differs from `rr_data`, `busy` is low in that cycle and `squash` is low in the next cycle. In this case `next_two_word` has no effect.
- R5: When the word is a compare-and-skip with equal operands and `next_two_word` is 0, `busy` is high in that cycle. `squash` and `busy` are then high for exactly one cycle, and the next unsquashed word is at the compare's PC+2.
- R6: When the word is a compare-and-skip with equal operands and `next_two_word` is 1, `busy` is high in that cycle. `squash` and `busy` are then high for exactly two cycles, and the next unsquashed word is at the compare's PC+3.
- R7: A word presented while `squash` is high is never decoded as a compare. Its operands and `next_two_word` do not extend or restart the skip.
- R8: Reset asserted during a skip ends the skip at once: `squash` is low in the cycle after the reset edge.
- R9: `busy` is high exactly in the cycles where a skip is resolved or `squash` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 16 | Instruction word fetched at `pc` |
| rd_data | input | 8 | Register value selected by `rd_sel` |
| rr_data | input | 8 | Register value selected by `rr_sel` |
| next_two_word | input | 1 | The instruction after this one occupies two words |
| pc | output | 16 | Address of the word presented this cycle |
| rd_sel | output | 5 | First operand register select |
| rr_sel | output | 5 | Second operand register select |
| squash | output | 1 | Current word is skipped; do not execute it |
| busy | output | 1 | Sequencer is resolving or performing a skip |

## Verification
Two functions can land in the same cycle. The first is the squash of a skipped word. The second is the decode of that same word, when the word is itself a compare-and-skip with equal operands and a two-word successor flag. The directed sequence places such a word in the squashed slot. The random stream hits this case often, because half its words carry the compare opcode and operand values are drawn from a tiny range. The expected result is that the skip length stays as first resolved, and no extra squash cycle appears. A second overlap, the PC wrapping in the middle of a skip, is reached by running the random stream past 65536 cycles and is judged against the bench's own modulo counter.

// File: rtl/skipseq_pkg.sv
// Shared constants and helpers for the compare-and-skip PC sequencer.
// Assumes a 16-bit instruction word with the opcode in the top six bits.
package skipseq_pkg;
    localparam int INSTR_W  = 16;
    localparam int SEL_W    = 5;
    localparam int OPC_W    = 6;
    localparam logic [OPC_W-1:0] CMP_SKIP_OPC = 6'b000100;
    localparam int SKIP_CNT_W = 2;

    // True when the word carries the compare-and-skip opcode.
    function automatic logic is_cmp_skip(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1 -: OPC_W] == CMP_SKIP_OPC;
    endfunction
endpackage

// File: rtl/skipseq_decode.sv
// Decoder: extracts the two register selects and flags the opcode.
// Assumes the split select layout: bit 8 tops the first select, bit 9 the second.
module skipseq_decode
    import skipseq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output logic               is_cmp,
    output logic [SEL_W-1:0]   sel_a,
    output logic [SEL_W-1:0]   sel_b
);
    // Purpose: slice out selects and opcode match.
    always_comb begin
        is_cmp = is_cmp_skip(word);
        sel_a  = {word[8], word[7:4]};
        sel_b  = {word[9], word[3:0]};
    end
endmodule

// File: rtl/skipseq_compare.sv
// Equality comparator built from per-bit match cells.
// Assumes both operands are presented in the same cycle as the decode.
module skipseq_compare #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              equal
);
    logic [DATA_W-1:0] bit_match;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Purpose: one bit-position match.
        assign bit_match[i] = ~(a[i] ^ b[i]);
    end

    // Purpose: all positions must match.
    assign equal = &bit_match;
endmodule

// File: rtl/skipseq_pcreg.sv
// Program counter register: steps one word per clock, wraps at 2^PC_W.
// Assumes the fetch side presents the word at pc every cycle.
module skipseq_pcreg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    // Purpose: reset to 0, otherwise step by one word.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + PC_STEP;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc == PC_W'($past(pc) + PC_STEP)); // R2
endmodule

// File: rtl/skipseq_skipctl.sv
// Skip controller: counts the words to squash after an equal compare.
// Assumes hit is never raised while squash is high (the top gates it).
module skipseq_skipctl
    import skipseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic next_long,
    output logic squash
);
    localparam logic [SKIP_CNT_W-1:0] SKIP_SHORT = SKIP_CNT_W'(1);
    localparam logic [SKIP_CNT_W-1:0] SKIP_LONG  = SKIP_CNT_W'(2);

    logic [SKIP_CNT_W-1:0] remain;

    // Purpose: load the skip length on a hit, count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (hit)         remain <= next_long ? SKIP_LONG : SKIP_SHORT;
        else if (remain != 0) remain <= remain - SKIP_CNT_W'(1);
    end

    // Purpose: any outstanding skipped word is squashed.
    assign squash = (remain != '0);

    AST_SKIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !next_long) |=> (squash ##1 !squash)); // R5
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && next_long) |=> (squash ##1 squash ##1 !squash)); // R6
endmodule

// File: rtl/skip_pc_sequencer.sv
// Top: PC sequencer for compare-and-skip-if-equal.
// Assumes register data for rd_sel/rr_sel and the two-word flag of the
// following instruction arrive combinationally in the same cycle.
module skip_pc_sequencer
    import skipseq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [DATA_W-1:0]  rr_data,
    input  logic               next_two_word,
    output logic [PC_W-1:0]    pc,
    output logic [SEL_W-1:0]   rd_sel,
    output logic [SEL_W-1:0]   rr_sel,
    output logic               squash,
    output logic               busy
);
    logic is_cmp;
    logic equal;
    logic hit;

    skipseq_decode u_decode (
        .word   (instr_word),
        .is_cmp (is_cmp),
        .sel_a  (rd_sel),
        .sel_b  (rr_sel)
    );

    skipseq_compare #(.DATA_W(DATA_W)) u_compare (
        .a     (rd_data),
        .b     (rr_data),
        .equal (equal)
    );

    skipseq_pcreg #(.PC_W(PC_W)) u_pcreg (
        .clk   (clk),
        .rst_n (rst_n),
        .pc    (pc)
    );

    skipseq_skipctl u_skipctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .next_long (next_two_word),
        .squash    (squash)
    );

    // Purpose: a squashed word is not decoded; only live equal compares skip.
    assign hit  = is_cmp && equal && !squash;
    // Purpose: busy spans the resolving cycle and all squashed cycles.
    assign busy = hit || squash;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !squash)); // R1
    AST_NO_SKIP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> !squash); // R4
    AST_SQUASH_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && $past(squash) && $past(rst_n)) |=> !squash); // R7
endmodule

// File: tb/skip_pc_sequencer_tb.sv
`timescale 1ns/1ps
module skip_pc_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = '0;
    logic [7:0]  rd_data = '0;
    logic [7:0]  rr_data = '0;
    logic        next_two_word = 1'b0;
    logic [15:0] pc;
    logic [4:0]  rd_sel, rr_sel;
    logic        squash, busy;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_pc = '0;
    int          m_rem = 0;

    skip_pc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word),
        .rd_data(rd_data), .rr_data(rr_data), .next_two_word(next_two_word),
        .pc(pc), .rd_sel(rd_sel), .rr_sel(rr_sel), .squash(squash), .busy(busy)
    );

    always #5 clk = ~clk;

    // Expected hit from requirements R3, R5, R6, R7.
    function automatic bit exp_hit(input logic [15:0] w, input logic [7:0] a,
                                   input logic [7:0] b, input int rem);
        return (rem == 0) && (w[15:10] == 6'b000100) && (a == b);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (time %0t)", req, act, exp, $time);
        end
    endtask

    // Apply one word for one cycle; check outputs, then advance the model.
    task automatic step(input bit r, input logic [15:0] w, input logic [7:0] a,
                        input logic [7:0] b, input bit lg);
        bit h;
        @(negedge clk);
        rst_n = r; instr_word = w; rd_data = a; rr_data = b; next_two_word = lg;
        #1;
        vectors++;
        chk("R1/R2 pc", pc, m_pc);
        chk("R5/R6/R7/R8 squash", squash, m_rem != 0);
        chk("R3 rd_sel", rd_sel, {w[8], w[7:4]});
        chk("R3 rr_sel", rr_sel, {w[9], w[3:0]});
        h = exp_hit(w, a, b, m_rem);
        if (r) chk("R4/R9 busy", busy, h || (m_rem != 0));
        if (!r) begin
            m_pc = '0; m_rem = 0;
        end else begin
            m_pc = m_pc + 16'd1;
            if (h) m_rem = lg ? 2 : 1;
            else if (m_rem != 0) m_rem--;
        end
    endtask

    localparam logic [15:0] CMP = 16'b0001_0000_0000_0000;

    initial begin
        void'($urandom(32'd2024));
        step(0, 16'h0, 8'h0, 8'h0, 0);
        step(0, 16'h0, 8'h0, 8'h0, 0);
        // R1 reset state checked in the first live step
        step(1, 16'h9400, 8'h1, 8'h1, 1);           // R4 not a compare
        step(1, CMP | 16'h0321, 8'h5, 8'h6, 1);     // R4 unequal, long ignored
        step(1, CMP | 16'h0155, 8'h7, 8'h7, 0);     // R5 short skip
        step(1, 16'h0000, 8'h0, 8'h0, 0);           // squashed word
        step(1, 16'h0000, 8'h0, 8'h0, 0);           // at PC+2, live
        step(1, CMP | 16'h02AA, 8'h3, 8'h3, 1);     // R6 long skip
        step(1, CMP, 8'h9, 8'h9, 1);                // R7 compare in squashed slot
        step(1, CMP, 8'h9, 8'h9, 1);                // R7 second squashed word
        step(1, 16'h1234, 8'h1, 8'h2, 0);           // at PC+3, live
        step(1, CMP | 16'h03FF, 8'hA, 8'hA, 1);     // R8 start skip
        step(0, 16'h0, 8'h0, 8'h0, 0);              // R8 reset mid-skip
        step(1, 16'h0, 8'h0, 8'h0, 0);              // R8 squash cleared
        // Random stream, long enough to wrap the PC (R2)
        for (int i = 0; i < 70000; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if ($urandom_range(0, 1) == 1) w[15:10] = 6'b000100;
            step(1, w, 8'($urandom_range(0, 2)), 8'($urandom_range(0, 2)),
                 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(190000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule